// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of a multi-channel event timer. It watches a shared free-running main counter and compares it against its own comparator register. When the counter reaches the comparator while the channel is armed and enabled, it emits a single-cycle fire pulse. Interrupt routing is left to a neighbour. Only the route field is stored here for that neighbour to read.

The channel holds a configuration register, a comparator and a hidden period register. In one-shot mode, a comparator write simply loads the comparator. In periodic mode, a comparator write loads the period instead, unless the set-value bit is set. After a periodic fire with a nonzero period, the channel advances the comparator by one period per clock until it is ahead of the counter again. A 32-bit mode narrows the comparator, the sums and the reach test to the low word, so counter wrap is handled by signed differences.

Top module: `cmp_chan`

## Requirements
- R1: After reset `cfg_o` reads `64'h00F0_0000_0000_0030`: the route capability sits in bits 63:32, and bits 5 and 4 are the read-only capability bits. `cmp_o` reads all ones and `fire_o` is low.
- R2: A configuration write changes only the bits set in mask 0x3F4E of `cfg_wdata_i`. These are bit 1 (level), bit 2 (timer enable), bit 3 (periodic), bit 6 (set-value), bit 8 (32-bit mode) and bits 13:9 (route). Every other bit of `cfg_o` keeps its value.
- R3: A comparator write loads the comparator when bit 3 is clear or bit 6 is set. Otherwise it loads the hidden period. Bit 6 reads 0 after any comparator write.
- R4: A configuration write that sets bit 8 clears the comparator's upper bits at the same edge. While bit 8 is set, comparator and period writes keep only bits 31:0.
- R5: `fire_o` never rises unless both `gen_en_i` and configuration bit 2 were set at the edge that produced it.
- R6: The counter has reached the comparator when (count − comparator), taken as a signed number, is ≥ 0. An armed, enabled channel that has reached the comparator raises `fire_o` for exactly one cycle, starting at the next clock edge. A comparator write in the same cycle suppresses that fire.
- R7: In one-shot mode the channel fires once and then stays silent while the counter is past the comparator. It rearms after a comparator write, or when the comparator is ahead of the counter again.
- R8: In periodic mode with a nonzero period, the fire edge adds the period to the comparator. The channel then adds one period per cycle, with no further fire, until the comparator is ahead. Only then does it rearm.
- R9: With bit 8 set, the reach test uses the 32-bit signed difference of the low words, and reload sums wrap modulo 2^32.
- R10: If the enable (global and timer) rises while the comparator is already reached, the channel fires at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CNT_W | Shared main counter value |
| gen_en_i | input | 1 | Global enable for all channels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data (low half-word) |
| cmp_we_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | CNT_W | Comparator or period write data |
| cfg_o | output | 64 | Configuration readback, route capability in 63:32 |
| cmp_o | output | CNT_W | Comparator readback |
| fire_o | output | 1 | One-cycle match event |

## Verification
Every register write and every counter value takes effect at the first rising edge after it is driven. The comparator, configuration and `fire_o` are all registered, so each result appears one edge after its stimulus. A reload run moves the comparator by one period per edge. The bench drives each vector on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Each table row therefore holds the state expected after one edge. Multi-cycle behaviour such as reload runs and enable-rise fires is spelled out as consecutive rows.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;
  localparam int CFG_W     = 16;
  localparam int B_LEVEL   = 1;
  localparam int B_EN      = 2;
  localparam int B_PER     = 3;
  localparam int B_PCAP    = 4;
  localparam int B_WCAP    = 5;
  localparam int B_SETV    = 6;
  localparam int B_M32     = 8;
  localparam int B_RT_LO   = 9;
  localparam int B_RT_HI   = 13;
  localparam logic [CFG_W-1:0] WR_MASK   = 16'h3F4E;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0030;
endpackage

// File: rtl/cmp_chan_cfg.sv
module cmp_chan_cfg
  import cmp_chan_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             cmp_we_i,
  output logic [63:0]      cfg_o,
  output logic             en_o,
  output logic             per_o,
  output logic             setv_o,
  output logic             m32_o,
  output logic             m32_set_o
);
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = (wdata_i & WR_MASK) | (cfg_q & ~WR_MASK);
    // set-value is consumed by any comparator write
    if (cmp_we_i) cfg_d[B_SETV] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o     = {ROUTE_CAP, {(32-CFG_W){1'b0}}, cfg_q};
  assign en_o      = cfg_q[B_EN];
  assign per_o     = cfg_q[B_PER];
  assign setv_o    = cfg_q[B_SETV];
  assign m32_o     = cfg_q[B_M32];
  assign m32_set_o = we_i & wdata_i[B_M32];

  // R3
  a_r3_setv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> !cfg_q[B_SETV]);
endmodule

// File: rtl/cmp_chan_reach.sv
module cmp_chan_reach #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             m32_i,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] HALF_W = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [31:0]      HALF_L = 32'h8000_0000;

  logic [CNT_W-1:0] diff_w;
  logic [31:0]      diff_l;

  assign diff_w  = count_i - cmp_i;
  assign diff_l  = count_i[31:0] - cmp_i[31:0];
  // signed difference >= 0 means the counter has reached the comparator
  assign reach_o = m32_i ? (diff_l < HALF_L) : (diff_w < HALF_W);
endmodule

// File: rtl/cmp_chan_core.sv
module cmp_chan_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             per_i,
  input  logic             setv_i,
  input  logic             m32_i,
  input  logic             m32_set_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             reach_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] LO_MASK = {{(CNT_W-32){1'b0}}, 32'hFFFF_FFFF};

  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d, keep, sum;
  logic             armed_q, armed_d, en_q, fire_q, fire_now, reload_on;

  assign keep      = (m32_i | m32_set_i) ? LO_MASK : '1;
  assign sum       = cmp_q + per_q;
  assign reload_on = per_i & (per_q != '0);
  assign fire_now  = en_i & reach_i & (armed_q | ~en_q) & ~cmp_we_i;

  always_comb begin
    cmp_d   = cmp_q;
    per_d   = per_q;
    armed_d = armed_q;
    if (cmp_we_i) begin
      if (!per_i || setv_i) cmp_d = cmp_wdata_i & keep;
      else                  per_d = cmp_wdata_i & keep;
      armed_d = 1'b1;
    end else if (fire_now) begin
      armed_d = 1'b0;
      if (reload_on) cmp_d = sum;
    end else if (en_i && !armed_q && reach_i && reload_on) begin
      cmp_d = sum;   // catch-up: one period per cycle
    end else if (!reach_i) begin
      armed_d = 1'b1;
    end
    cmp_d = cmp_d & keep;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '1;
      per_q   <= '0;
      armed_q <= 1'b1;
      en_q    <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      per_q   <= per_d;
      armed_q <= armed_d;
      en_q    <= en_i;
      fire_q  <= fire_now;
    end
  end

  assign cmp_o  = cmp_q;
  assign fire_o = fire_q;

  // R5
  a_r5_fire_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(en_i));
  // R6
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  // R4
  a_r4_high_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m32_i |-> (cmp_q[CNT_W-1:32] == '0));
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
  import cmp_chan_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             gen_en_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [63:0]      cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             fire_o
);
  logic t_en, per, setv, m32, m32_set, reach;

  cmp_chan_cfg #(.ROUTE_CAP(ROUTE_CAP)) u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .cmp_we_i  (cmp_we_i),
    .cfg_o     (cfg_o),
    .en_o      (t_en),
    .per_o     (per),
    .setv_o    (setv),
    .m32_o     (m32),
    .m32_set_o (m32_set)
  );

  cmp_chan_reach #(.CNT_W(CNT_W)) u_reach (
    .count_i (count_i),
    .cmp_i   (cmp_o),
    .m32_i   (m32),
    .reach_o (reach)
  );

  cmp_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .en_i        (gen_en_i & t_en),
    .per_i       (per),
    .setv_i      (setv),
    .m32_i       (m32),
    .m32_set_i   (m32_set),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .reach_i     (reach),
    .cmp_o       (cmp_o),
    .fire_o      (fire_o)
  );
endmodule

// File: tb/cmp_chan_tb_top.sv
`timescale 1ns/1ps
module cmp_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] count = '0;
  logic        gen_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wd = '0;
  logic        cmp_we = 1'b0;
  logic [63:0] cmp_wd = '0;
  logic [63:0] cfg_o, cmp_o;
  logic        fire_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_chan dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .count_i(count), .gen_en_i(gen_en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_we_i(cmp_we),
    .cmp_wdata_i(cmp_wd), .cfg_o(cfg_o), .cmp_o(cmp_o), .fire_o(fire_o)
  );

  typedef struct packed {
    logic        gen;
    logic [63:0] cnt;
    logic        cfg_we;
    logic [15:0] cfg_wd;
    logic        cmp_we;
    logic [63:0] cmp_wd;
    logic        fire;
    logic [63:0] cmp;
    logic [15:0] cfg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 64'd10,  1'b0, 16'h0000, 1'b1, 64'd100, 1'b0, 64'd100, 16'h0030, 4'd3},
    '{1'b1, 64'd20,  1'b1, 16'h0004, 1'b0, 64'd0,   1'b0, 64'd100, 16'h0034, 4'd5},
    '{1'b1, 64'd99,  1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd100, 16'h0034, 4'd6},
    '{1'b1, 64'd100, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b1, 64'd100, 16'h0034, 4'd6},
    '{1'b1, 64'd101, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd100, 16'h0034, 4'd7},
    '{1'b1, 64'd150, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd100, 16'h0034, 4'd7},
    '{1'b1, 64'd150, 1'b1, 16'h004C, 1'b0, 64'd0,   1'b0, 64'd100, 16'h007C, 4'd3},
    '{1'b1, 64'd150, 1'b0, 16'h0000, 1'b1, 64'd200, 1'b0, 64'd200, 16'h003C, 4'd3},
    '{1'b1, 64'd150, 1'b0, 16'h0000, 1'b1, 64'd50,  1'b0, 64'd200, 16'h003C, 4'd3},
    '{1'b1, 64'd200, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b1, 64'd250, 16'h003C, 4'd8},
    '{1'b1, 64'd210, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd250, 16'h003C, 4'd8},
    '{1'b1, 64'd380, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b1, 64'd300, 16'h003C, 4'd8},
    '{1'b1, 64'd380, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd350, 16'h003C, 4'd8},
    '{1'b1, 64'd380, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd400, 16'h003C, 4'd8},
    '{1'b1, 64'd380, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd400, 16'h003C, 4'd8},
    '{1'b1, 64'd400, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b1, 64'd450, 16'h003C, 4'd8},
    '{1'b0, 64'd450, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd450, 16'h003C, 4'd5},
    '{1'b0, 64'd500, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd450, 16'h003C, 4'd5},
    '{1'b1, 64'd500, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b1, 64'd500, 16'h003C, 4'd10},
    '{1'b1, 64'd500, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd550, 16'h003C, 4'd8},
    '{1'b1, 64'd500, 1'b0, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd550, 16'h003C, 4'd8},
    '{1'b1, 64'd500, 1'b1, 16'h0000, 1'b0, 64'd0,   1'b0, 64'd550, 16'h0030, 4'd2},
    '{1'b1, 64'h1_0000_0000, 1'b0, 16'h0000, 1'b1, 64'h1_0000_0010, 1'b0, 64'h1_0000_0010, 16'h0030, 4'd3},
    '{1'b1, 64'h1_0000_0000, 1'b1, 16'h0104, 1'b0, 64'd0, 1'b0, 64'h10, 16'h0134, 4'd4},
    '{1'b1, 64'h1_0000_000F, 1'b0, 16'h0000, 1'b0, 64'd0, 1'b0, 64'h10, 16'h0134, 4'd9},
    '{1'b1, 64'h2_0000_0010, 1'b0, 16'h0000, 1'b0, 64'd0, 1'b1, 64'h10, 16'h0134, 4'd9},
    '{1'b1, 64'h2_0000_0010, 1'b0, 16'h0000, 1'b1, 64'hABCD_0000_0000_0005, 1'b0, 64'h5, 16'h0134, 4'd4},
    '{1'b1, 64'hFFFF_FFF0, 1'b0, 16'h0000, 1'b0, 64'd0, 1'b0, 64'h5, 16'h0134, 4'd9},
    '{1'b1, 64'h1_0000_0005, 1'b0, 16'h0000, 1'b0, 64'd0, 1'b1, 64'h5, 16'h0134, 4'd9},
    '{1'b1, 64'h1_0000_0005, 1'b1, 16'h014C, 1'b0, 64'd0, 1'b0, 64'h5, 16'h017C, 4'd3},
    '{1'b1, 64'hFFFF_FFE0, 1'b0, 16'h0000, 1'b1, 64'hFFFF_FFF0, 1'b0, 64'hFFFF_FFF0, 16'h013C, 4'd3},
    '{1'b1, 64'hFFFF_FFE0, 1'b0, 16'h0000, 1'b1, 64'h20, 1'b0, 64'hFFFF_FFF0, 16'h013C, 4'd3},
    '{1'b1, 64'hFFFF_FFF0, 1'b0, 16'h0000, 1'b0, 64'd0, 1'b1, 64'h10, 16'h013C, 4'd9},
    '{1'b1, 64'h1_0000_0000, 1'b0, 16'h0000, 1'b0, 64'd0, 1'b0, 64'h10, 16'h013C, 4'd9}
  };

  function automatic string rname(logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "cfg reset", cfg_o, 64'h00F0_0000_0000_0030);
    chk("R1", "cmp reset", cmp_o, '1);
    chk("R1", "fire reset", {63'd0, fire_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      gen_en = VECS[i].gen;
      count  = VECS[i].cnt;
      cfg_we = VECS[i].cfg_we;
      cfg_wd = VECS[i].cfg_wd;
      cmp_we = VECS[i].cmp_we;
      cmp_wd = VECS[i].cmp_wd;
      @(posedge clk);
      @(negedge clk);
      chk(rname(VECS[i].req), $sformatf("vec%0d fire", i), {63'd0, fire_o}, {63'd0, VECS[i].fire});
      chk(rname(VECS[i].req), $sformatf("vec%0d cmp", i), cmp_o, VECS[i].cmp);
      chk(rname(VECS[i].req), $sformatf("vec%0d cfg", i), {48'd0, cfg_o[15:0]}, {48'd0, VECS[i].cfg});
    end

    // R2: writable-bit mask with all data bits set, then cleared
    gen_en = 1'b0; cmp_we = 1'b0;
    cfg_we = 1'b1; cfg_wd = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    chk("R2", "cfg all ones", cfg_o, 64'h00F0_0000_0000_3F7E);
    cfg_wd = 16'h0000;
    @(posedge clk); @(negedge clk);
    chk("R2", "cfg all zeros", cfg_o, 64'h00F0_0000_0000_0030);
    cfg_we = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule